// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block records the outcome of every finished transmission as one 8-bit status entry and holds these entries in a small first-in first-out store. The transmit engine pushes one entry per completed frame. The push carries four outcome flags: an interrupt-on-success request, jabber, underrun and maximum collisions. The host always sees the oldest entry on the status output. A host write to the status register pops that entry.

When a push arrives and the store is full, the new entry is dropped and the overflow bit of the entry at the head is set, so the host learns that completions were lost. A pending indication tells the interrupt logic that unread entries exist. A one-cycle event pulse marks pushes that deserve host attention. Fatal outcomes (jabber or underrun) latch a transmitter-halted flag, and only the transmit reset input clears it.

Top module: `tx_cmpl_stack`

## Requirements
- R1: After reset and whenever the store is empty, `status_o` reads 8'h00 and `pending_o` is low.
- R2: A stored entry reads with bit 7 = 1, bit 6 = intr-request (`push_flags_i[3]`), bit 5 = jabber (`push_flags_i[2]`), bit 4 = underrun (`push_flags_i[1]`), bit 3 = max-collision (`push_flags_i[0]`), bit 2 = overflow, and bits 1:0 = 0.
- R3: A push while the store holds DEPTH (default 4) entries and no pop is requested is discarded, and bit 2 of the head entry becomes 1 from the next cycle on.
- R4: Entries are presented oldest first. A pop (`pop_i` high for one cycle) removes the head entry, and the next entry appears on the following cycle.
- R5: A pop while the store is empty has no effect.
- R6: A push and a pop in the same cycle on a full store remove the head and store the new entry, with no overflow marking.
- R7: `pending_o` is high exactly when the store holds at least one entry.
- R8: `tx_event_o` is high for one cycle, the cycle after a push whose flags are not all zero. This happens even when the push is discarded. In all other cycles it is low.
- R9: `tx_halted_o` goes high the cycle after a push with jabber or underrun set, and stays high until a cycle with `tx_reset_i` high and no such push. If both happen in the same cycle, the flag stays set.
- R10: `tx_reset_i` does not change the stored entries or their count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Transmit engine pushes one completion entry |
| push_flags_i | input | 4 | {intr-request, jabber, underrun, max-collision} |
| pop_i | input | 1 | Host write: remove the head entry |
| tx_reset_i | input | 1 | Transmit reset, clears the halted flag |
| status_o | output | 8 | Head entry, or zero when empty |
| pending_o | output | 1 | Store is not empty |
| tx_event_o | output | 1 | One-cycle pulse for a notable push |
| tx_halted_o | output | 1 | Transmitter needs reset after a fatal error |

## Verification
The hardest situations to reach are the interactions at the full boundary. These are an overflow marking landing on a head that changes through later pops, and a push and pop in the same cycle on a full store. The bench fills the store to depth, then drives overflow pushes, simultaneous push-pop and pops of every kind. It sweeps all 16 flag values at each occupancy and then runs a long random mix of all four inputs against a queue model. That model also covers transmit reset colliding with a fatal push.

// File: rtl/tx_cmpl_pkg.sv
package tx_cmpl_pkg;

    typedef struct packed {
        logic intr_req;
        logic jabber;
        logic underrun;
        logic max_coll;
    } cmpl_flags_t;

    typedef struct packed {
        logic        complete;
        cmpl_flags_t flags;
        logic        overflow;
        logic [1:0]  unused;
    } cmpl_entry_t;

    localparam int ENTRY_W   = $bits(cmpl_entry_t);
    localparam int OVF_BIT   = 2;

    function automatic cmpl_entry_t make_entry(input cmpl_flags_t f);
        cmpl_entry_t e;
        e.complete = 1'b1;
        e.flags    = f;
        e.overflow = 1'b0;
        e.unused   = 2'b00;
        return e;
    endfunction

    function automatic logic is_fatal(input cmpl_flags_t f);
        return f.jabber | f.underrun;
    endfunction

    function automatic logic is_notable(input cmpl_flags_t f);
        return f.intr_req | f.jabber | f.underrun | f.max_coll;
    endfunction

endpackage

// File: rtl/tx_cmpl_store.sv
module tx_cmpl_store
    import tx_cmpl_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        push,
    input  cmpl_entry_t push_entry,
    input  logic        pop,
    output cmpl_entry_t head_entry,
    output logic        not_empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    cmpl_entry_t [DEPTH-1:0] slots;
    logic [PTR_W-1:0] head_ptr, tail_ptr;
    logic [CNT_W-1:0] count;

    logic do_pop, accept, spill;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        do_pop = pop && (count != '0);
        accept = push && ((count != FULL_CNT) || do_pop);
        spill  = push && !accept;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slots    <= '0;
            head_ptr <= '0;
            tail_ptr <= '0;
            count    <= '0;
        end else begin
            if (accept) begin
                slots[tail_ptr] <= push_entry;
                tail_ptr        <= bump(tail_ptr);
            end
            if (spill) begin
                slots[head_ptr].overflow <= 1'b1;
            end
            if (do_pop) begin
                head_ptr <= bump(head_ptr);
            end
            case ({accept, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_comb begin
        not_empty  = (count != '0);
        head_entry = not_empty ? slots[head_ptr] : '0;
    end

endmodule

// File: rtl/tx_cmpl_events.sv
module tx_cmpl_events
    import tx_cmpl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        push,
    input  cmpl_flags_t flags,
    input  logic        tx_reset,
    output logic        event_pulse,
    output logic        halted
);
    always_ff @(posedge clk) begin
        if (rst) begin
            event_pulse <= 1'b0;
            halted      <= 1'b0;
        end else begin
            event_pulse <= push && is_notable(flags);
            if (push && is_fatal(flags)) begin
                halted <= 1'b1;
            end else if (tx_reset) begin
                halted <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tx_cmpl_stack.sv
module tx_cmpl_stack
    import tx_cmpl_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push_i,
    input  logic [3:0] push_flags_i,
    input  logic       pop_i,
    input  logic       tx_reset_i,
    output logic [7:0] status_o,
    output logic       pending_o,
    output logic       tx_event_o,
    output logic       tx_halted_o
);
    cmpl_flags_t flags;
    cmpl_entry_t new_entry, head;

    assign flags     = cmpl_flags_t'(push_flags_i);
    assign new_entry = make_entry(flags);

    tx_cmpl_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst        (rst),
        .push       (push_i),
        .push_entry (new_entry),
        .pop        (pop_i),
        .head_entry (head),
        .not_empty  (pending_o)
    );

    tx_cmpl_events u_events (
        .clk         (clk),
        .rst         (rst),
        .push        (push_i),
        .flags       (flags),
        .tx_reset    (tx_reset_i),
        .event_pulse (tx_event_o),
        .halted      (tx_halted_o)
    );

    assign status_o = head;

endmodule

// File: rtl/tx_cmpl_stack_chk.sv
module tx_cmpl_stack_chk (
    input logic       clk,
    input logic       rst,
    input logic       push_i,
    input logic [3:0] push_flags_i,
    input logic       pop_i,
    input logic       tx_reset_i,
    input logic [7:0] status_o,
    input logic       pending_o,
    input logic       tx_event_o,
    input logic       tx_halted_o
);
    p_empty_zero_r1: assert property (@(posedge clk) disable iff (rst)
        !pending_o |-> status_o == 8'h00);

    p_entry_shape_r2: assert property (@(posedge clk) disable iff (rst)
        pending_o |-> (status_o[7] && status_o[1:0] == 2'b00));

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (pending_o && !pop_i && status_o[2]) |=> status_o[2]);

    p_pop_empty_r5: assert property (@(posedge clk) disable iff (rst)
        (!pending_o && !push_i) |=> !pending_o);

    p_push_pending_r7: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i) |=> pending_o);

    p_event_cause_r8: assert property (@(posedge clk) disable iff (rst)
        tx_event_o |-> ($past(push_i) && $past(push_flags_i) != 4'h0));

    p_halt_set_r9: assert property (@(posedge clk) disable iff (rst)
        (push_i && (push_flags_i[2] || push_flags_i[1])) |=> tx_halted_o);

    p_halt_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (tx_halted_o && !tx_reset_i) |=> tx_halted_o);

    p_reset_keeps_r10: assert property (@(posedge clk) disable iff (rst)
        (tx_reset_i && !push_i && !pop_i) |=> $stable(status_o));

endmodule

bind tx_cmpl_stack tx_cmpl_stack_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .push_i       (push_i),
    .push_flags_i (push_flags_i),
    .pop_i        (pop_i),
    .tx_reset_i   (tx_reset_i),
    .status_o     (status_o),
    .pending_o    (pending_o),
    .tx_event_o   (tx_event_o),
    .tx_halted_o  (tx_halted_o)
);

// File: tb/tx_cmpl_stack_tb.sv
module tx_cmpl_stack_tb;
    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       push_i = 1'b0;
    logic [3:0] push_flags_i = 4'h0;
    logic       pop_i = 1'b0;
    logic       tx_reset_i = 1'b0;
    logic [7:0] status_o;
    logic       pending_o, tx_event_o, tx_halted_o;

    int tests = 0;
    int fails = 0;

    logic [7:0] mq[$];
    logic       exp_event = 1'b0;
    logic       exp_halt  = 1'b0;

    always #5 clk = ~clk;

    tx_cmpl_stack #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .push_i(push_i), .push_flags_i(push_flags_i),
        .pop_i(pop_i), .tx_reset_i(tx_reset_i), .status_o(status_o),
        .pending_o(pending_o), .tx_event_o(tx_event_o), .tx_halted_o(tx_halted_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        logic [7:0] eh;
        eh = (mq.size() > 0) ? mq[0] : 8'h00;
        chk({tag, " R2/R4 status"}, status_o, eh);
        chk({tag, " R7 pending"}, {7'd0, pending_o}, {7'd0, mq.size() > 0});
        chk({tag, " R8 event"}, {7'd0, tx_event_o}, {7'd0, exp_event});
        chk({tag, " R9 halted"}, {7'd0, tx_halted_o}, {7'd0, exp_halt});
    endtask

    // drive one cycle, update model, check after the edge
    task automatic step(input logic push, input logic [3:0] fl, input logic pop,
                        input logic txr, input string tag);
        logic do_pop, accept;
        push_i = push; push_flags_i = fl; pop_i = pop; tx_reset_i = txr;
        do_pop = pop && (mq.size() > 0);
        accept = push && ((mq.size() < DEPTH) || do_pop);
        if (do_pop) void'(mq.pop_front());
        if (accept) mq.push_back({1'b1, fl, 3'b000});
        else if (push) mq[0] = mq[0] | 8'h04;
        exp_event = push && (fl != 4'h0);
        if (push && (fl[2] || fl[1])) exp_halt = 1'b1;
        else if (txr) exp_halt = 1'b0;
        @(posedge clk);
        #1;
        push_i = 1'b0; pop_i = 1'b0; tx_reset_i = 1'b0; push_flags_i = 4'h0;
        check_all(tag);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        chk("R1 reset status", status_o, 8'h00);
        chk("R1 reset pending", {7'd0, pending_o}, 8'h00);
        chk("R9 reset halted", {7'd0, tx_halted_o}, 8'h00);

        // R5 pop while empty
        step(1'b0, 4'h0, 1'b1, 1'b0, "R5 pop empty");

        // R2 every flag value, single entry in and out
        for (int f = 0; f < 16; f++) begin
            step(1'b1, 4'(f), 1'b0, 1'b0, "R2 sweep push");
            chk("R2 encode", status_o, {1'b1, 4'(f), 3'b000});
            step(1'b0, 4'h0, 1'b1, 1'b0, "R4 sweep pop");
            step(1'b0, 4'h0, 1'b0, 1'b1, "R9 clear");
        end

        // R3/R4 fill, overflow, drain at each occupancy with all flags
        for (int occ = 0; occ <= DEPTH; occ++) begin
            for (int f = 0; f < 16; f++) begin
                for (int k = 0; k < occ; k++) step(1'b1, 4'(k + 1), 1'b0, 1'b0, "R4 fill");
                step(1'b1, 4'(f), 1'b0, 1'b0, "R3 push at occupancy");
                step(1'b1, 4'(f), 1'b1, 1'b0, "R6 push+pop");
                step(1'b0, 4'h0, 1'b0, 1'b1, "R10 txreset keeps store");
                while (mq.size() > 0) step(1'b0, 4'h0, 1'b1, 1'b0, "R4 drain");
            end
        end

        // R3 explicit: full store, spill sets head bit 2
        for (int k = 0; k < DEPTH; k++) step(1'b1, 4'h1, 1'b0, 1'b0, "R3 fill");
        step(1'b1, 4'h8, 1'b0, 1'b0, "R3 spill");
        chk("R3 head overflow", status_o, 8'h8C);
        step(1'b0, 4'h0, 1'b1, 1'b0, "R3 pop after spill");
        chk("R3 next entry clean", status_o, 8'h88);
        while (mq.size() > 0) step(1'b0, 4'h0, 1'b1, 1'b0, "R4 drain");

        // R9 fatal push and tx reset in same cycle: set wins
        step(1'b1, 4'h4, 1'b0, 1'b1, "R9 set wins");
        chk("R9 set wins direct", {7'd0, tx_halted_o}, 8'h01);
        step(1'b0, 4'h0, 1'b1, 1'b1, "R9 clear");

        // random mix against the queue model
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] | r[1], r[7:4], r[2], (r[11:8] == 4'h0), "R3..R10 random");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule